// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a small page-organised serial EEPROM. The whole device is built in synchronous logic. A system clock oversamples the bus clock and data lines. The block drives the data line only as an open-drain pull-down enable. The memory is an internal byte array of `MEM_BYTES` bytes, from 128 to 2048, arranged as 16-byte pages. After reset every location holds the erased value 0xFF.

A master writes by sending a starting address and then 1 to 16 data bytes. Those bytes collect in a page buffer, and the STOP that ends the transfer commits them to the array in one step. A timed busy window follows the commit, and during it the target ignores its own address, so the master can poll until the write is finished. Reads begin either at the current address or at an address set by a dummy write followed by a repeated START. The address advances after every byte sent. The memory size decides how many of the three select bits in the address byte are compared with the strap pins and how many become high memory-address bits.

Top module: `i2c_eeprom_target`

## Requirements
- R1: Bus activity is ignored until a START is seen, where a START is the data line falling while the clock is high. A STOP, the data line rising while the clock is high, ends any transfer and releases the data line.
- R2: The first byte after a START is the address byte, sent MSB first. Its bits 7:4 must equal 4'b1010 and bit 0 selects read (1) or write (0). Of the select bits 3:1, the number that become memory-address bits a8 upward, counted from bit 1, is 0 for 128 or 256 bytes, 1 for 512, 2 for 1024 and 3 for 2048. The remaining upper select bits must equal `strap_i` in the same positions, or the byte is not acknowledged.
- R3: The target acknowledges a matching address byte, the memory-address byte and every accepted data byte by pulling the data line low for the whole ninth clock. The data line never changes while the clock is high.
- R4: In a write, the byte after the address byte is memory-address bits 7:0, and later bytes are data. Data bytes fill the current 16-byte page. The low four address bits wrap from 15 to 0 and the page bits stay the same.
- R5: Buffered data reaches the array only when a STOP ends the write. A repeated START before the STOP discards the buffered data.
- R6: For `BUSY_CYCLES` clocks after a commit, no address byte is acknowledged. A transfer that committed nothing starts no busy window.
- R7: While `wp_i` is high, data bytes are not acknowledged and nothing is committed. The memory-address byte is still acknowledged.
- R8: In a read, bytes are sent MSB first and the data line is released in the ninth clock. The next byte follows while the master acknowledges. After a master NACK the line stays released until the next START.
- R9: The address advances by one after every byte sent, and it wraps from the last location to 0.
- R10: After reset the data line is released and every location reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| strap_i | input | 3 | Select straps compared with address-byte bits 3:1 |
| wp_i | input | 1 | Write protect, active high |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench builds the block with `MEM_BYTES` = 512, so exactly one select bit becomes memory-address bit a8. That makes both the strap comparison on the two upper select bits and the page selection in the upper half of the array observable. `BUSY_CYCLES` = 400 is short enough that an ACK poll issued straight after a STOP falls inside the busy window and a later poll falls outside it. Random page writes of random length, start offset and data cross the page wrap. A read that starts near the top of the 512-byte array crosses the wrap to address 0.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam logic [3:0] DEV_ID     = 4'b1010;
    localparam int         PAGE_BYTES = 16;
    localparam int         PAGE_AW    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADDR,
        ST_WR,
        ST_RD,
        ST_SKIP
    } xfer_st_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic       we;
        logic [3:0] idx;
        logic [7:0] data;
    } buf_wr_t;

    // number of select bits that turn into memory-address bits
    function automatic int hi_bits(input int aw);
        return (aw > 8) ? aw - 8 : 0;
    endfunction

    // select bits that still have to match the straps
    function automatic logic [2:0] strap_mask(input int hb);
        logic [2:0] m;
        m = 3'b111;
        return m << hb;
    endfunction

endpackage

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor
    import eeprom_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [1:0] scl_sync;
    logic [1:0] sda_sync;
    logic       scl_q;
    logic       sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_q    <= scl_sync[1];
            sda_q    <= sda_sync[1];
        end
    end

    always_comb begin
        ev.scl      = scl_sync[1];
        ev.sda      = sda_sync[1];
        ev.scl_rise = scl_sync[1] & ~scl_q;
        ev.scl_fall = ~scl_sync[1] & scl_q;
        ev.start    = scl_sync[1] & scl_q & sda_q & ~sda_sync[1];
        ev.stop     = scl_sync[1] & scl_q & ~sda_q & sda_sync[1];
    end

endmodule

// File: rtl/i2c_eeprom_fsm.sv
module i2c_eeprom_fsm
    import eeprom_pkg::*;
#(
    parameter int MEM_BYTES = 512
) (
    input  logic                          clk,
    input  logic                          rst,
    input  bus_ev_t                       ev,
    input  logic [2:0]                    strap_i,
    input  logic                          wp_i,
    input  logic                          busy_i,
    input  logic [7:0]                    rd_data_i,
    output logic                          sda_oe_o,
    output logic [$clog2(MEM_BYTES)-1:0]  rd_addr_o,
    output logic [$clog2(MEM_BYTES)-5:0]  page_o,
    output buf_wr_t                       buf_wr_o,
    output logic                          buf_clear_o,
    output logic                          commit_o
);

    localparam int          AW        = $clog2(MEM_BYTES);
    localparam int          HB        = hi_bits(AW);
    localparam logic [2:0]  SMASK     = strap_mask(HB);
    localparam logic [10:0] ADDR_MASK = 11'(MEM_BYTES - 1);

    xfer_st_t    st;
    logic [3:0]  bitcnt;
    logic        ack_ph;
    logic [7:0]  shreg;
    logic [7:0]  txreg;
    logic [10:0] ptr;
    logic        oe;
    logic        rd_go;
    logic        pending;
    logic        dev_hit;

    assign dev_hit = (shreg[7:4] == DEV_ID)
                   && (((shreg[3:1] ^ strap_i) & SMASK) == 3'b000)
                   && !busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            bitcnt      <= '0;
            ack_ph      <= 1'b0;
            shreg       <= '0;
            txreg       <= '0;
            ptr         <= '0;
            oe          <= 1'b0;
            rd_go       <= 1'b0;
            pending     <= 1'b0;
            buf_wr_o    <= '0;
            buf_clear_o <= 1'b0;
            commit_o    <= 1'b0;
        end else begin
            buf_wr_o.we <= 1'b0;
            buf_clear_o <= 1'b0;
            commit_o    <= 1'b0;
            if (ev.start) begin
                st          <= ST_DEV;
                bitcnt      <= '0;
                ack_ph      <= 1'b0;
                oe          <= 1'b0;
                buf_clear_o <= pending;
                pending     <= 1'b0;
            end else if (ev.stop) begin
                st      <= ST_IDLE;
                bitcnt  <= '0;
                ack_ph  <= 1'b0;
                oe      <= 1'b0;
                if (pending && !wp_i) commit_o    <= 1'b1;
                else if (pending)     buf_clear_o <= 1'b1;
                pending <= 1'b0;
            end else if (st != ST_IDLE && st != ST_SKIP) begin
                if (ev.scl_rise) begin
                    if (!ack_ph && bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ack_ph && st == ST_RD) begin
                        rd_go <= ~ev.sda;
                    end
                end else if (ev.scl_fall) begin
                    if (ack_ph) begin
                        ack_ph <= 1'b0;
                        bitcnt <= '0;
                        oe     <= 1'b0;
                        if (st == ST_RD) begin
                            if (rd_go) begin
                                txreg <= rd_data_i;
                                oe    <= ~rd_data_i[7];
                                ptr   <= (ptr + 11'd1) & ADDR_MASK;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end else if (bitcnt == 4'd8) begin
                        ack_ph <= 1'b1;
                        oe     <= 1'b0;
                        case (st)
                            ST_DEV: begin
                                if (dev_hit) begin
                                    oe  <= 1'b1;
                                    ptr <= {shreg[3:1] & ~SMASK, ptr[7:0]} & ADDR_MASK;
                                    if (shreg[0]) begin
                                        st    <= ST_RD;
                                        rd_go <= 1'b1;
                                    end else begin
                                        st <= ST_ADDR;
                                    end
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end
                            ST_ADDR: begin
                                oe  <= 1'b1;
                                ptr <= {ptr[10:8], shreg} & ADDR_MASK;
                                st  <= ST_WR;
                            end
                            ST_WR: begin
                                if (wp_i) begin
                                    st          <= ST_SKIP;
                                    pending     <= 1'b0;
                                    buf_clear_o <= 1'b1;
                                end else begin
                                    oe            <= 1'b1;
                                    buf_wr_o.we   <= 1'b1;
                                    buf_wr_o.idx  <= ptr[3:0];
                                    buf_wr_o.data <= shreg;
                                    ptr[3:0]      <= ptr[3:0] + 4'd1;
                                    pending       <= 1'b1;
                                end
                            end
                            default: oe <= 1'b0;
                        endcase
                    end else if (st == ST_RD && bitcnt != 4'd0) begin
                        oe <= ~txreg[3'(4'd7 - bitcnt)];
                    end
                end
            end
        end
    end

    assign sda_oe_o  = oe;
    assign rd_addr_o = ptr[AW-1:0];
    assign page_o    = ptr[AW-1:PAGE_AW];

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store
    import eeprom_pkg::*;
#(
    parameter int MEM_BYTES   = 512,
    parameter int BUSY_CYCLES = 1000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  buf_wr_t                       buf_wr_i,
    input  logic                          buf_clear_i,
    input  logic                          commit_i,
    input  logic [$clog2(MEM_BYTES)-5:0]  page_i,
    input  logic [$clog2(MEM_BYTES)-1:0]  rd_addr_i,
    output logic [7:0]                    rd_data_o,
    output logic                          busy_o
);

    localparam int AW = $clog2(MEM_BYTES);
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic [7:0]            mem  [MEM_BYTES];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    logic [BW-1:0]         busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (commit_i) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (pvalid[i]) mem[{page_i, PAGE_AW'(i)}] <= pbuf[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (buf_wr_i.we) pbuf[buf_wr_i.idx] <= buf_wr_i.data;
    end

    always_ff @(posedge clk) begin
        if (rst || commit_i || buf_clear_i) pvalid <= '0;
        else if (buf_wr_i.we)               pvalid[buf_wr_i.idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                   busy_cnt <= '0;
        else if (commit_i)         busy_cnt <= BW'(BUSY_CYCLES);
        else if (busy_cnt != '0)   busy_cnt <= busy_cnt - 1'b1;
    end

    assign busy_o    = (busy_cnt != '0);
    assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import eeprom_pkg::*;
#(
    parameter int MEM_BYTES   = 512,
    parameter int BUSY_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);

    localparam int AW = $clog2(MEM_BYTES);

    bus_ev_t         ev;
    buf_wr_t         buf_wr;
    logic            buf_clear;
    logic            commit;
    logic            busy;
    logic [7:0]      rd_data;
    logic [AW-1:0]   rd_addr;
    logic [AW-5:0]   page;
    logic            scl_s;
    logic            stop_p;

    assign scl_s  = ev.scl;
    assign stop_p = ev.stop;

    i2c_line_monitor u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_eeprom_fsm #(.MEM_BYTES(MEM_BYTES)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .strap_i     (strap_i),
        .wp_i        (wp_i),
        .busy_i      (busy),
        .rd_data_i   (rd_data),
        .sda_oe_o    (sda_oe_o),
        .rd_addr_o   (rd_addr),
        .page_o      (page),
        .buf_wr_o    (buf_wr),
        .buf_clear_o (buf_clear),
        .commit_o    (commit)
    );

    eeprom_store #(.MEM_BYTES(MEM_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
        .clk         (clk),
        .rst         (rst),
        .buf_wr_i    (buf_wr),
        .buf_clear_i (buf_clear),
        .commit_i    (commit),
        .page_i      (page),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .busy_o      (busy)
    );

endmodule

// File: rtl/eeprom_checker.sv
module eeprom_checker (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic sda_oe,
    input logic busy,
    input logic stop_p,
    input logic commit,
    input logic wp_i
);

    AST_OE_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R3

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        stop_p |=> !sda_oe); // R1

    AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(stop_p)); // R5

    AST_COMMIT_UNPROTECTED: assert property (@(posedge clk) disable iff (rst)
        commit |-> !$past(wp_i)); // R7

    AST_BUSY_FOLLOWS_COMMIT: assert property (@(posedge clk) disable iff (rst)
        commit |=> busy); // R6

    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe); // R6

endmodule

bind i2c_eeprom_target eeprom_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .scl_s  (scl_s),
    .sda_oe (sda_oe_o),
    .busy   (busy),
    .stop_p (stop_p),
    .commit (commit),
    .wp_i   (wp_i)
);

// File: tb/sim_i2c_eeprom_target.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_target;

    localparam int MEM   = 512;
    localparam int BUSY  = 400;
    localparam int Q     = 6;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [7:0] model [MEM];
    logic [7:0] rbuf  [20];
    logic [7:0] wdat  [16];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_eeprom_target #(.MEM_BYTES(MEM), .BUSY_CYCLES(BUSY)) u0 (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .strap_i  (STRAP),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    function automatic logic [7:0] devb(input logic [8:0] a, input logic rw);
        return {4'hA, STRAP[2], STRAP[1], a[8], rw};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = (sda_line == 1'b0);
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = ~mack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    // random read of n bytes starting at address a; checks R8 release after NACK
    task automatic rd_seq(input logic [8:0] a, input int n);
        bit k0, k1, k2;
        bit quiet;
        bus_start();
        send_byte(devb(a, 1'b0), k0);
        send_byte(a[7:0], k1);
        bus_start();
        send_byte(devb(a, 1'b1), k2);
        chk(k0 && k1 && k2, "R3", "read setup acks", {k0, k1, k2}, 3'b111);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            if (sda_line == 1'b0) quiet = 1'b0;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        chk(quiet, "R8", "line released after master NACK", quiet, 1);
        bus_stop();
    endtask

    // write n bytes of wdat from address a; dacks reports data-byte acks
    task automatic wr_seq(input logic [8:0] a, input int n, input bit do_stop,
                          output bit hdr_ok, output bit dacks);
        bit k0, k1, kd;
        bus_start();
        send_byte(devb(a, 1'b0), k0);
        send_byte(a[7:0], k1);
        hdr_ok = k0 && k1;
        dacks = 1'b1;
        for (int i = 0; i < n; i++) begin
            send_byte(wdat[i], kd);
            if (!kd) dacks = 1'b0;
        end
        if (do_stop) bus_stop();
    endtask

    task automatic poll(output bit acked);
        bus_start();
        send_byte(devb(9'd0, 1'b0), acked);
        bus_stop();
    endtask

    task automatic model_write(input logic [8:0] a, input int n);
        for (int i = 0; i < n; i++) model[{a[8:4], 4'(a[3:0] + i)}] = wdat[i];
    endtask

    task automatic check_page(input logic [8:0] base, input string req);
        rd_seq({base[8:4], 4'h0}, 16);
        for (int i = 0; i < 16; i++) begin
            logic [8:0] ad;
            ad = {base[8:4], 4'(i)};
            chk(rbuf[i] == model[ad], req, "page readback", rbuf[i], model[ad]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        bit ack, hdr, dk;
        int polls;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < MEM; i++) model[i] = 8'hFF;
        tick(10);
        rst = 1'b0;
        tick(5);
        chk(sda_oe == 1'b0, "R10", "oe after reset", sda_oe, 0);

        // R1: address byte clocked without START gets no ACK
        send_byte(devb(9'd0, 1'b0), ack);
        chk(!ack, "R1", "no start no ack", ack, 0);

        // R10: erased content
        rd_seq(9'h123, 2);
        chk(rbuf[0] == 8'hFF && rbuf[1] == 8'hFF, "R10", "erased read", rbuf[0], 8'hFF);

        // R2: wrong ID and strap mismatch
        bus_start(); send_byte(8'hBA, ack); bus_stop();
        chk(!ack, "R2", "wrong device id", ack, 0);
        bus_start(); send_byte({4'hA, ~STRAP[2], STRAP[1], 1'b0, 1'b0}, ack); bus_stop();
        chk(!ack, "R2", "strap mismatch", ack, 0);
        bus_start(); send_byte({4'hA, STRAP[2], STRAP[1], 1'b1, 1'b1}, ack);
        chk(ack, "R2", "a8 select bit not compared", ack, 1);
        bus_stop();

        // R4/R5/R6: random page writes
        for (int it = 0; it < 5; it++) begin
            logic [8:0] a;
            int n;
            a = 9'($urandom % MEM);
            n = 1 + int'($urandom % 16);
            if (it == 0) begin a = 9'h1FD; n = 16; end
            for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
            wr_seq(a, n, 1'b1, hdr, dk);
            chk(hdr && dk, "R3", "write acks", {hdr, dk}, 2'b11);
            model_write(a, n);
            poll(ack);
            chk(!ack, "R6", "nack while busy", ack, 0);
            polls = 0;
            do begin poll(ack); polls++; end while (!ack && polls < 10);
            chk(ack, "R6", "ack after busy window", ack, 1);
            check_page(a, "R4");
        end

        // R5: repeated START discards buffered bytes
        wdat[0] = 8'h5A; wdat[1] = 8'hA5;
        wr_seq(9'h040, 2, 1'b0, hdr, dk);
        rd_seq(9'h040, 2);
        chk(rbuf[0] == model[9'h040] && rbuf[1] == model[9'h041], "R5",
            "restart discards", rbuf[0], model[9'h040]);
        poll(ack);
        chk(ack, "R6", "no busy without commit", ack, 1);

        // R7: write protect
        wp = 1'b1;
        wdat[0] = 8'h11; wdat[1] = 8'h22;
        wr_seq(9'h0C3, 2, 1'b1, hdr, dk);
        chk(hdr, "R7", "address byte acked under wp", hdr, 1);
        chk(!dk, "R7", "data nacked under wp", dk, 0);
        wp = 1'b0;
        poll(ack);
        chk(ack, "R7", "no commit under wp", ack, 1);
        rd_seq(9'h0C3, 1);
        chk(rbuf[0] == model[9'h0C3], "R7", "protected byte kept", rbuf[0], model[9'h0C3]);

        // R9: sequential read wraps to address 0
        rd_seq(9'h1FE, 4);
        chk(rbuf[0] == model[9'h1FE], "R9", "byte 1FE", rbuf[0], model[9'h1FE]);
        chk(rbuf[1] == model[9'h1FF], "R9", "byte 1FF", rbuf[1], model[9'h1FF]);
        chk(rbuf[2] == model[9'h000], "R9", "wrap to 0", rbuf[2], model[9'h000]);
        chk(rbuf[3] == model[9'h001], "R9", "byte 001", rbuf[3], model[9'h001]);

        // R8: current-address read continues after the last byte
        bus_start();
        send_byte(devb(9'h000, 1'b1), ack);
        recv_byte(1'b0, rbuf[0]);
        bus_stop();
        chk(ack && rbuf[0] == model[9'h002], "R8", "current address read",
            rbuf[0], model[9'h002]);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule